// File: doc/BRIEF.md
# HDLC Receive Address Screen

This block sits between an HDLC receive deframer and a receive FIFO. The deframer hands over each frame as a stream of bytes, with one marker on the first byte and one on the last. A 3-bit mode input chooses how the block screens each frame. It can compare the first byte against service access point identifiers (SAPI), the second byte against terminal endpoint identifiers (TEI), or both. It can also skip screening or pass raw octets with no framing at all.

The block writes only the bytes a frame is allowed to forward into the FIFO write port. It tags the last forwarded byte of a frame so that the FIFO can record frame boundaries. A frame that is rejected, or that ends before any byte could be forwarded, writes nothing and raises a one-cycle drop pulse.

The accept decision is made on the compared byte itself. Every forwarded byte can therefore go straight to the write port, one register stage later, without holding the frame in a buffer.

Top module: `hdlc_addr_screen`

## Requirements
- R1: While reset is asserted, and until the internal reset release has completed, `fifo_we` and `frame_drop` are 0.
- R2: Each forwarded byte appears on `fifo_byte` with `fifo_we`=1 exactly one clock after it was presented. `fifo_eof` is 1 only on a forwarded byte that was presented with `rx_last`=1.
- R3: Mode 3'b110 forwards every byte of a frame, from the byte marked `rx_first` through the byte marked `rx_last`.
- R4: Mode 3'b111 masks bits [1:0] of byte 0 and compares it with `sapi_own_a`, `sapi_own_b` and 8'hFC, all masked the same way. On a hit, bytes 1 onward are forwarded and byte 0 is not.
- R5: Mode 3'b101 compares byte 1, all 8 bits, with `tei_own_a`, `tei_own_b` and 8'hFF. On a hit, bytes 2 onward are forwarded; bytes 0 and 1 are not.
- R6: Mode 3'b010 compares byte 0, all 8 bits, with `tei_own_a`, `tei_own_b` and 8'hFF. On a hit, bytes 1 onward are forwarded.
- R7: Mode 3'b011 requires byte 0 to pass the SAPI compare of R4 and byte 1 to pass the TEI compare of R5. On a hit, bytes 2 onward are forwarded.
- R8: Mode 3'b100 is transparent. Every byte with `rx_valid`=1 is forwarded, `rx_first` and `rx_last` are ignored, `fifo_eof` stays 0, and no drop pulse is raised.
- R9: A frame that forwards no byte writes nothing to the FIFO and raises `frame_drop` for one clock, one clock after its `rx_last` byte. This covers a failed compare, a frame that ends at or before its compared byte, and the reserved modes 3'b000 and 3'b001.
- R10: The mode is sampled on the `rx_first` byte and held until that frame's `rx_last` byte. Changes on `mode_sel` in between do not affect the frame.
- R11: When no frame is open and the mode is not transparent, a byte without `rx_first` is ignored. An `rx_first` byte always starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Screening mode |
| sapi_own_a | input | 8 | First SAPI compare value (bits [1:0] ignored) |
| sapi_own_b | input | 8 | Second SAPI compare value (bits [1:0] ignored) |
| tei_own_a | input | 8 | First TEI compare value |
| tei_own_b | input | 8 | Second TEI compare value |
| rx_valid | input | 1 | Received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_first | input | 1 | Byte is the first of a frame |
| rx_last | input | 1 | Byte is the last of a frame |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_byte | output | 8 | FIFO write data |
| fifo_eof | output | 1 | Written byte ends the frame |
| frame_drop | output | 1 | One-cycle pulse: frame discarded |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit saturating position counter, a SAPI mask of 8'hFC, and group values 8'hFC and 8'hFF. With a 2-bit counter, the byte positions 0, 1 and 2 and later, on which every forwarding rule depends, are all reached by short frames. Frames of one to six bytes are therefore enough to cover compare-at-the-end drops, group matches with the command/response bits set, and mode changes in the middle of a frame.

// File: rtl/hdlc_scr_pkg.sv
package hdlc_scr_pkg;

  typedef enum logic [2:0] {
    M_RSV0   = 3'b000,
    M_RSV1   = 3'b001,
    M_ONEADR = 3'b010,
    M_TWOADR = 3'b011,
    M_TRANSP = 3'b100,
    M_TEI    = 3'b101,
    M_ALL    = 3'b110,
    M_SAPI   = 3'b111
  } scr_mode_e;

  // Byte position from which a screened frame is forwarded; 3 means never.
  function automatic logic [1:0] fwd_from(input scr_mode_e m);
    case (m)
      M_ALL:              fwd_from = 2'd0;
      M_SAPI, M_ONEADR:   fwd_from = 2'd1;
      M_TEI, M_TWOADR:    fwd_from = 2'd2;
      default:            fwd_from = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/hdlc_scr_rsync.sv
module hdlc_scr_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/hdlc_scr_cmp.sv
// Matches a byte against NREF programmable values plus one fixed group
// value, after masking away the bits that MASK clears.
module hdlc_scr_cmp #(
  parameter int            W     = 8,
  parameter int            NREF  = 2,
  parameter logic [W-1:0]  MASK  = '1,
  parameter logic [W-1:0]  GROUP = '1
) (
  input  logic [W-1:0]      val,
  input  logic [NREF*W-1:0] refs,
  output logic              hit
);
  logic [NREF:0] match;

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    assign match[i] = ((val ^ refs[i*W +: W]) & MASK) == '0;
  end

  assign match[NREF] = ((val ^ GROUP) & MASK) == '0;
  assign hit         = |match;
endmodule

// File: rtl/hdlc_scr_ctrl.sv
// Frame tracker and forwarding decision. POS_W must be at least 2.
module hdlc_scr_ctrl
  import hdlc_scr_pkg::*;
#(
  parameter int BW    = 8,
  parameter int POS_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [2:0]    mode,
  input  logic          sapi_hit,
  input  logic          tei_hit,
  output logic          o_we,
  output logic [BW-1:0] o_data,
  output logic          o_last,
  output logic          o_drop
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

  logic             open_q, open_d;
  scr_mode_e        mode_q, mode_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             ok_q, ok_d;
  logic             st_en;

  scr_mode_e        mode_in, eff;
  logic             start, in_frm, transp, first, second, ok_n, wr;
  logic [POS_W-1:0] idx;

  always_comb begin
    mode_in = scr_mode_e'(mode);
    start   = in_valid && in_sof;
    eff     = start ? mode_in : mode_q;
    in_frm  = in_valid && (start ? (mode_in != M_TRANSP) : open_q);
    transp  = in_valid && !in_frm && (mode_in == M_TRANSP);
    idx     = start ? '0 : pos_q;
    first   = (idx == '0);
    second  = (idx == POS_ONE);

    case (eff)
      M_ALL:    ok_n = first ? 1'b1 : ok_q;
      M_SAPI:   ok_n = first ? sapi_hit : ok_q;
      M_ONEADR: ok_n = first ? tei_hit : ok_q;
      M_TEI:    ok_n = first ? 1'b1 : (second ? (ok_q && tei_hit) : ok_q);
      M_TWOADR: ok_n = first ? sapi_hit : (second ? (ok_q && tei_hit) : ok_q);
      default:  ok_n = 1'b0;
    endcase

    wr = in_frm && ok_n && (idx >= POS_W'(fwd_from(eff)));

    o_we   = wr || transp;
    o_data = in_data;
    o_last = wr && in_eof;
    o_drop = in_frm && in_eof && !wr;
  end

  // next-state
  always_comb begin
    st_en  = in_frm || start;
    open_d = open_q;
    mode_d = mode_q;
    pos_d  = pos_q;
    ok_d   = ok_q;
    if (in_frm) begin
      open_d = !in_eof;
      mode_d = eff;
      pos_d  = (idx == POS_MAX) ? POS_MAX : idx + POS_ONE;
      ok_d   = ok_n;
    end else if (start) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      mode_q <= M_RSV0;
      pos_q  <= '0;
      ok_q   <= 1'b0;
    end else if (st_en) begin
      open_q <= open_d;
      mode_q <= mode_d;
      pos_q  <= pos_d;
      ok_q   <= ok_d;
    end
  end
endmodule

// File: rtl/hdlc_scr_oreg.sv
module hdlc_scr_oreg #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_we,
  input  logic [BW-1:0] d_data,
  input  logic          d_last,
  input  logic          d_drop,
  output logic          q_we,
  output logic [BW-1:0] q_data,
  output logic          q_last,
  output logic          q_drop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_we   <= 1'b0;
      q_last <= 1'b0;
      q_drop <= 1'b0;
    end else begin
      q_we   <= d_we;
      q_last <= d_last;
      q_drop <= d_drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
    end else if (d_we) begin
      q_data <= d_data;
    end
  end
endmodule

// File: rtl/hdlc_addr_screen.sv
module hdlc_addr_screen #(
  parameter int            BW         = 8,
  parameter int            POS_W      = 2,
  parameter logic [BW-1:0] SAPI_MASK  = 8'hFC,
  parameter logic [BW-1:0] SAPI_GROUP = 8'hFC,
  parameter logic [BW-1:0] TEI_GROUP  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic [BW-1:0] sapi_own_a,
  input  logic [BW-1:0] sapi_own_b,
  input  logic [BW-1:0] tei_own_a,
  input  logic [BW-1:0] tei_own_b,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_byte,
  input  logic          rx_first,
  input  logic          rx_last,
  output logic          fifo_we,
  output logic [BW-1:0] fifo_byte,
  output logic          fifo_eof,
  output logic          frame_drop
);
  logic          rst_s_n;
  logic          sapi_hit, tei_hit;
  logic          c_we, c_last, c_drop;
  logic [BW-1:0] c_data;

  hdlc_scr_rsync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  hdlc_scr_cmp #(.W(BW), .NREF(2), .MASK(SAPI_MASK), .GROUP(SAPI_GROUP)) u_sapi (
    .val  (rx_byte),
    .refs ({sapi_own_b, sapi_own_a}),
    .hit  (sapi_hit)
  );

  hdlc_scr_cmp #(.W(BW), .NREF(2), .MASK('1), .GROUP(TEI_GROUP)) u_tei (
    .val  (rx_byte),
    .refs ({tei_own_b, tei_own_a}),
    .hit  (tei_hit)
  );

  hdlc_scr_ctrl #(.BW(BW), .POS_W(POS_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_valid (rx_valid),
    .in_data  (rx_byte),
    .in_sof   (rx_first),
    .in_eof   (rx_last),
    .mode     (mode_sel),
    .sapi_hit (sapi_hit),
    .tei_hit  (tei_hit),
    .o_we     (c_we),
    .o_data   (c_data),
    .o_last   (c_last),
    .o_drop   (c_drop)
  );

  hdlc_scr_oreg #(.BW(BW)) u_oreg (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .d_we   (c_we),
    .d_data (c_data),
    .d_last (c_last),
    .d_drop (c_drop),
    .q_we   (fifo_we),
    .q_data (fifo_byte),
    .q_last (fifo_eof),
    .q_drop (frame_drop)
  );
endmodule

// File: rtl/hdlc_scr_chk.sv
module hdlc_scr_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_sel,
  input logic          rx_valid,
  input logic [BW-1:0] rx_byte,
  input logic          rx_first,
  input logic          rx_last,
  input logic          fifo_we,
  input logic [BW-1:0] fifo_byte,
  input logic          fifo_eof,
  input logic          frame_drop
);
  // R2: a write carries the byte presented one clock earlier
  a_r2_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> ($past(rx_valid) && fifo_byte == $past(rx_byte)));

  // R2: the end tag only follows a byte marked last
  a_r2_eof_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && fifo_eof) |-> $past(rx_valid && rx_last));

  // R9: a drop pulse follows a last byte
  a_r9_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> $past(rx_valid && rx_last));

  // R9: a dropped frame writes nothing in the drop cycle
  a_r9_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> !fifo_we);

  // R8: a first-marked byte in transparent mode yields no end tag and no drop
  a_r8_transp_plain: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_valid && rx_first && mode_sel == 3'b100) |-> (fifo_we && !fifo_eof && !frame_drop));
endmodule

bind hdlc_addr_screen hdlc_scr_chk #(.BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .mode_sel   (mode_sel),
  .rx_valid   (rx_valid),
  .rx_byte    (rx_byte),
  .rx_first   (rx_first),
  .rx_last    (rx_last),
  .fifo_we    (fifo_we),
  .fifo_byte  (fifo_byte),
  .fifo_eof   (fifo_eof),
  .frame_drop (frame_drop)
);

// File: tb/sim_hdlc_addr_screen.sv
module sim_hdlc_addr_screen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b110;
  logic [7:0] sa_a = 8'h40, sa_b = 8'h84, te_a = 8'h22, te_b = 8'h95;
  logic       rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       fifo_we, fifo_eof, frame_drop;
  logic [7:0] fifo_byte;

  always #10 clk = ~clk;

  hdlc_addr_screen u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .sapi_own_a(sa_a), .sapi_own_b(sa_b), .tei_own_a(te_a), .tei_own_b(te_b),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_first(rx_first), .rx_last(rx_last),
    .fifo_we(fifo_we), .fifo_byte(fifo_byte), .fifo_eof(fifo_eof), .frame_drop(frame_drop)
  );

  int n_run = 0, n_fail = 0, cyc = 0;

  // reference state
  bit       m_open = 0;
  bit [2:0] m_mode = 0;
  int       m_pos = 0;
  bit       m_ok = 0;
  bit       e_we = 0, e_last = 0, e_drop = 0;
  bit [7:0] e_data = 0;
  string    e_tag = "R1";
  string    tag_force = "";

  function automatic bit sapi_m(input bit [7:0] b);
    return ((b & 8'hFC) == (sa_a & 8'hFC)) || ((b & 8'hFC) == (sa_b & 8'hFC)) ||
           ((b & 8'hFC) == 8'hFC);
  endfunction

  function automatic bit tei_m(input bit [7:0] b);
    return (b == te_a) || (b == te_b) || (b == 8'hFF);
  endfunction

  task automatic model(input bit v, input bit [7:0] d, input bit s, input bit e, input bit [2:0] md);
    int start;
    e_we = 0; e_last = 0; e_drop = 0; e_data = d; e_tag = "R11";
    if (v) begin
      if (s && md == 3'b100) begin
        m_open = 0; e_we = 1; e_tag = "R8";
      end else if (!s && !m_open) begin
        if (md == 3'b100) begin e_we = 1; e_tag = "R8"; end
      end else begin
        if (s) begin m_open = 1; m_mode = md; m_pos = 0; m_ok = 0; end
        case (m_mode)
          3'b110: begin start = 0; e_tag = "R3"; if (m_pos == 0) m_ok = 1; end
          3'b111: begin start = 1; e_tag = "R4"; if (m_pos == 0) m_ok = sapi_m(d); end
          3'b101: begin start = 2; e_tag = "R5";
                    if (m_pos == 0) m_ok = 1; else if (m_pos == 1) m_ok = m_ok && tei_m(d); end
          3'b010: begin start = 1; e_tag = "R6"; if (m_pos == 0) m_ok = tei_m(d); end
          3'b011: begin start = 2; e_tag = "R7";
                    if (m_pos == 0) m_ok = sapi_m(d); else if (m_pos == 1) m_ok = m_ok && tei_m(d); end
          default: begin start = 99; e_tag = "R9"; m_ok = 0; end
        endcase
        e_we   = m_ok && (m_pos >= start);
        e_last = e_we && e;
        e_drop = e && !e_we;
        if (e_drop) e_tag = "R9";
        m_pos++;
        if (e) m_open = 0;
      end
    end
    if (tag_force != "") e_tag = tag_force;
  endtask

  task automatic check_out();
    bit bad;
    n_run++;
    bad = (fifo_we !== e_we) || (frame_drop !== e_drop) ||
          (e_we && ((fifo_byte !== e_data) || (fifo_eof !== e_last)));
    if (bad) begin
      n_fail++;
      $display("FAIL %s: we=%0b byte=%02h eof=%0b drop=%0b expected we=%0b byte=%02h eof=%0b drop=%0b",
               e_tag, fifo_we, fifo_byte, fifo_eof, frame_drop, e_we, e_data, e_last, e_drop);
    end
  endtask

  task automatic step(input bit v, input bit [7:0] d, input bit s, input bit e, input bit [2:0] md);
    @(negedge clk);
    check_out();
    rx_valid = v; rx_byte = d; rx_first = s; rx_last = e; mode_sel = md;
    model(v, d, s, e, md);
  endtask

  task automatic frame3(input bit [2:0] md, input bit [7:0] b0, input bit [7:0] b1, input bit [7:0] b2);
    step(1, b0, 1, 0, md);
    step(1, b1, 0, 0, md);
    step(1, b2, 0, 1, md);
  endtask

  function automatic bit [7:0] pick(input int pos);
    int r = $urandom % 9;
    if (pos == 0) begin
      case (r)
        0: return sa_a | 8'($urandom % 4);
        1: return sa_b;
        2: return 8'hFC | 8'($urandom % 4);
        3: return te_a;
        4: return 8'hFF;
        default: return 8'($urandom);
      endcase
    end
    case (r)
      0: return te_a;
      1: return te_b;
      2: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    // R1: reset and release window
    tag_force = "R1";
    repeat (3) step(0, 0, 0, 0, 3'b110);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0, 3'b110);

    // R2: latency and end tag
    tag_force = "R2";
    frame3(3'b110, 8'h11, 8'h22, 8'h33);
    // R3: no screening
    tag_force = "R3";
    frame3(3'b110, 8'h00, 8'h5A, 8'hA5);
    // R4: group SAPI with low bits set, own SAPI with low bits set, miss
    tag_force = "R4";
    frame3(3'b111, 8'hFE, 8'h01, 8'h02);
    frame3(3'b111, 8'h43, 8'h03, 8'h04);
    frame3(3'b111, 8'h10, 8'h05, 8'h06);
    // R5: TEI hit and group TEI
    tag_force = "R5";
    frame3(3'b101, 8'h00, 8'h95, 8'h07);
    frame3(3'b101, 8'h00, 8'hFF, 8'h08);
    // R6 / R7
    tag_force = "R6";
    frame3(3'b010, 8'h22, 8'h09, 8'h0A);
    tag_force = "R7";
    frame3(3'b011, 8'h84, 8'h22, 8'h0B);
    frame3(3'b011, 8'h84, 8'h23, 8'h0C);
    // R9: short frames, reserved mode
    tag_force = "R9";
    step(1, 8'h40, 1, 1, 3'b111);
    step(1, 8'h00, 1, 0, 3'b101);
    step(1, 8'h22, 0, 1, 3'b101);
    frame3(3'b001, 8'h40, 8'h22, 8'h0D);
    // R8: transparent ignores markers
    tag_force = "R8";
    frame3(3'b100, 8'h7E, 8'h7E, 8'h81);
    // R10: mode change mid-frame
    tag_force = "R10";
    step(1, 8'h40, 1, 0, 3'b111);
    step(1, 8'h0E, 0, 0, 3'b100);
    step(1, 8'h0F, 0, 1, 3'b000);
    // R11: stray byte with no frame open, then restart inside an open frame
    tag_force = "R11";
    step(1, 8'h99, 0, 1, 3'b110);
    step(1, 8'h41, 1, 0, 3'b110);
    frame3(3'b111, 8'h10, 8'h12, 8'h13);
    step(0, 0, 0, 0, 3'b110);
    tag_force = "";

    // constrained random frames
    for (int f = 0; f < 600; f++) begin
      bit [2:0] md = 3'($urandom % 8);
      int len = 1 + ($urandom % 6);
      if ($urandom % 10 == 0) step(1, 8'($urandom), 0, 0, md);
      for (int i = 0; i < len; i++) begin
        bit [2:0] mnow = (i > 0 && $urandom % 8 == 0) ? 3'($urandom % 8) : md;
        step(1, (i < 2) ? pick(i) : 8'($urandom), i == 0, i == len - 1, mnow);
      end
      repeat ($urandom % 3) step(0, 0, 0, 0, md);
    end
    step(0, 0, 0, 0, 3'b110);
    step(0, 0, 0, 0, 3'b110);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule